// File: doc/BRIEF.md
# Packed Unsigned Saturating Left Shifter

This unit shifts unsigned data left by a constant amount and clamps instead of wrapping. The operand is 128 bits wide. It is split into 8-, 16-, 32- or 64-bit lanes. Each active lane is shifted left with zeros filling the low bits. A lane whose true result does not fit in its width becomes all ones. One 7-bit immediate selects both the lane width and the shift amount. The upper four bits are the size code and the lower three bits are the low immediate.

In vector mode the unit processes every lane of a 64-bit or 128-bit datapath. In scalar mode it processes lane zero only. Illegal encodings raise a flag and produce a zero result. Each operation is accepted with a valid strobe, and the result appears one clock later. A sticky saturation bit collects overflow events until it is cleared on purpose.

Top module: `pkshl_top`

## Requirements
- R1: The lane width W is 8 when the size code is 0001, 16 for 001x, 32 for 01xx and 64 for 1xxx, so the highest set bit decides. The shift amount is the unsigned value of {sizeCode, lowImm} minus W, which is always between 0 and W-1.
- R2: Each active lane is read as unsigned and shifted left by the shift amount. Zeros fill the low bits and there is no rounding.
- R3: When any 1 bit of a lane would leave the top of the lane, that lane's result is all ones (2^W-1).
- R4: With vecMode=0, only the lowest W bits of the operand are processed. All result bits above W are zero.
- R5: With vecMode=1 and wideSel=1, all 128/W lanes are processed. With wideSel=0, only bits 63:0 are processed and result bits 127:64 are zero.
- R6: A size code of 0000 performs no shift and gives an all-zero result. In scalar mode it sets undefFlag. In vector mode it sets otherClass and leaves undefFlag at 0.
- R7: vecMode=1 with sizeCode[3]=1 and wideSel=0 is reserved. It sets undefFlag and gives an all-zero result.
- R8: satSticky becomes 1 one cycle after an accepted, legal operation in which any active lane saturated. Lanes outside the active region never affect it. It falls only on a clearSticky cycle. If a saturating operation and clearSticky arrive in the same cycle, the bit ends up set.
- R9: outValid is inValid delayed by one clock. On the same edge result, undefFlag and otherClass take the new operation's values. They hold while inValid is low, whatever the other inputs do.
- R10: While rstN is low, outValid, result, undefFlag, otherClass and satSticky are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Accept an operation this cycle |
| operand | input | 128 | Packed source lanes |
| sizeCode | input | 4 | Upper immediate field: lane width and upper shift bits |
| lowImm | input | 3 | Lower immediate field |
| wideSel | input | 1 | Vector datapath 128 bits (1) or 64 bits (0) |
| vecMode | input | 1 | Vector (1) or scalar (0) operation |
| clearSticky | input | 1 | Clear the sticky saturation bit |
| outValid | output | 1 | Registered result is new this cycle |
| result | output | 128 | Registered shifted lanes |
| undefFlag | output | 1 | Last operation was undefined or reserved |
| otherClass | output | 1 | Last operation was a vector with size code 0000 |
| satSticky | output | 1 | Cumulative saturation bit |

## Verification
The hardest case to reach is the boundary of the active region. The test must show that saturating values in lanes that are not processed leave both the result and the sticky bit alone. To reach it, the sticky bit is first cleared. Then the bench applies operands whose inactive half or inactive upper lanes would overflow, while the active lanes sit exactly at the largest value that still fits. A second operation then pushes one active lane one step past that limit, so the sticky bit is seen to rise only when an active lane overflows.

// File: rtl/pkshl_pkg.sv
package pkshl_pkg;
  localparam int DataW    = 128;
  localparam int ByteCnt  = DataW / 8;
  localparam int SizeW    = 4;
  localparam int LowW     = 3;
  localparam int ShiftW   = 6;
  localparam int WidthCnt = 4;

  typedef struct packed {
    logic [1:0]         sizeSel;
    logic [ShiftW-1:0]  shiftAmt;
    logic [ByteCnt-1:0] byteKeep;
    logic               load;
  } shlStrobe_t;
endpackage

// File: rtl/pkshl_ctrl.sv
module pkshl_ctrl
  import pkshl_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [SizeW-1:0] sizeCode,
  input  logic [LowW-1:0]  lowImm,
  input  logic             wideSel,
  input  logic             vecMode,
  input  logic             clearSticky,
  input  logic             satAny,
  output shlStrobe_t       strobe,
  output logic             outValid,
  output logic             undefFlag,
  output logic             otherClass,
  output logic             satSticky
);
  localparam int ImmW = SizeW + LowW;

  logic [1:0]         sizeSel;
  logic [ImmW-1:0]    widthBits;
  logic [ImmW-1:0]    shiftFull;
  logic               zeroCode;
  logic               isUndef;
  logic               isOther;
  logic               doOp;
  logic [ByteCnt-1:0] keep;

  always_comb begin
    if (sizeCode[3])      sizeSel = 2'd3;
    else if (sizeCode[2]) sizeSel = 2'd2;
    else if (sizeCode[1]) sizeSel = 2'd1;
    else                  sizeSel = 2'd0;
    widthBits = ImmW'(8) << sizeSel;
    shiftFull = {sizeCode, lowImm} - widthBits;
    zeroCode  = (sizeCode == '0);
    isUndef   = (!vecMode && zeroCode) || (vecMode && sizeCode[3] && !wideSel);
    isOther   = vecMode && zeroCode;
    doOp      = !(isUndef || isOther);
    if (!doOp)        keep = '0;
    else if (vecMode) keep = wideSel ? {ByteCnt{1'b1}} : {{(ByteCnt/2){1'b0}}, {(ByteCnt/2){1'b1}}};
    else              keep = (ByteCnt'(1) << (4'd1 << sizeSel)) - ByteCnt'(1);
  end

  always_comb begin
    strobe.sizeSel  = sizeSel;
    strobe.shiftAmt = shiftFull[ShiftW-1:0];
    strobe.byteKeep = keep;
    strobe.load     = inValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      undefFlag  <= 1'b0;
      otherClass <= 1'b0;
      satSticky  <= 1'b0;
    end else begin
      outValid  <= inValid;
      satSticky <= (satSticky & ~clearSticky) | (inValid & doOp & satAny);
      if (inValid) begin
        undefFlag  <= isUndef;
        otherClass <= isOther;
      end
    end
  end
endmodule

// File: rtl/pkshl_datapath.sv
module pkshl_datapath
  import pkshl_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [DataW-1:0] operand,
  input  shlStrobe_t       strobe,
  output logic [DataW-1:0] result,
  output logic             satAny
);
  logic [DataW-1:0]    resByW [WidthCnt];
  logic [WidthCnt-1:0] satByW;
  logic [DataW-1:0]    keepMask;
  logic [DataW-1:0]    nextRes;

  for (genvar g = 0; g < WidthCnt; g++) begin : gWidth
    localparam int W = 8 << g;
    localparam int N = DataW / W;
    logic [N-1:0] laneSat;
    for (genvar l = 0; l < N; l++) begin : gLane
      logic [W-1:0] lane;
      logic [W-1:0] keptMask;
      logic         ovf;
      always_comb begin
        lane     = operand[l*W +: W];
        keptMask = {W{1'b1}} >> strobe.shiftAmt;
        ovf      = |(lane & ~keptMask);
        resByW[g][l*W +: W] = ovf ? {W{1'b1}} : (lane << strobe.shiftAmt);
        laneSat[l] = ovf & strobe.byteKeep[(l*W)/8];
      end
    end
    assign satByW[g] = |laneSat;
  end

  always_comb begin
    for (int b = 0; b < ByteCnt; b++) keepMask[b*8 +: 8] = {8{strobe.byteKeep[b]}};
    nextRes = resByW[strobe.sizeSel] & keepMask;
    satAny  = satByW[strobe.sizeSel];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            result <= '0;
    else if (strobe.load) result <= nextRes;
  end
endmodule

// File: rtl/pkshl_top.sv
module pkshl_top
  import pkshl_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [DataW-1:0] operand,
  input  logic [SizeW-1:0] sizeCode,
  input  logic [LowW-1:0]  lowImm,
  input  logic             wideSel,
  input  logic             vecMode,
  input  logic             clearSticky,
  output logic             outValid,
  output logic [DataW-1:0] result,
  output logic             undefFlag,
  output logic             otherClass,
  output logic             satSticky
);
  shlStrobe_t strobe;
  logic       satAny;

  pkshl_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .sizeCode(sizeCode),
    .lowImm(lowImm), .wideSel(wideSel), .vecMode(vecMode),
    .clearSticky(clearSticky), .satAny(satAny), .strobe(strobe),
    .outValid(outValid), .undefFlag(undefFlag), .otherClass(otherClass),
    .satSticky(satSticky)
  );

  pkshl_datapath uData (
    .clk(clk), .rstN(rstN), .operand(operand), .strobe(strobe),
    .result(result), .satAny(satAny)
  );
endmodule

// File: rtl/pkshl_checker.sv
module pkshl_checker
  import pkshl_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             wideSel,
  input logic             vecMode,
  input logic             clearSticky,
  input logic             outValid,
  input logic [DataW-1:0] result,
  input logic             undefFlag,
  input logic             otherClass,
  input logic             satSticky
);
  p_valid_rise_r9: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_valid_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  p_scalar_upper_r4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !vecMode) |=> (result[DataW-1:64] == '0));
  p_narrow_upper_r5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && vecMode && !wideSel) |=> (result[DataW-1:64] == '0));
  p_illegal_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && (undefFlag || otherClass)) |-> (result == '0));
  p_sticky_fall_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(satSticky) |-> $past(clearSticky));
  p_sticky_rise_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(satSticky) |-> $past(inValid));
  p_flags_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(undefFlag && otherClass));
endmodule

bind pkshl_top pkshl_checker chk (.*);

// File: tb/pkshl_top_test.sv
`timescale 1ns/1ps
module pkshl_top_test;
  logic clk = 1'b0, rstN = 1'b0, inValid = 1'b0, wideSel = 1'b0, vecMode = 1'b0, clearSticky = 1'b0;
  logic [127:0] operand = '0;
  logic [3:0] sizeCode = '0;
  logic [2:0] lowImm = '0;
  logic outValid, undefFlag, otherClass, satSticky;
  logic [127:0] result;
  int checks = 0, fails = 0;
  bit expSticky = 1'b0;

  always #2 clk = ~clk;

  pkshl_top uut (.*);

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  function automatic logic [127:0] model(input logic [127:0] op, input logic [3:0] code,
      input logic [2:0] imm, input bit q, input bit vec, output bit sat, output bit undef, output bit other);
    int w, sh, lanes;
    logic [127:0] res, mask, laneV, wide;
    sat = 0; undef = 0; other = 0; res = '0;
    if (code[3]) w = 64; else if (code[2]) w = 32; else if (code[1]) w = 16; else w = 8;
    sh = int'({code, imm}) - w;
    if (code == 4'd0) begin
      if (vec) other = 1; else undef = 1;
      return '0;
    end
    if (vec && code[3] && !q) begin undef = 1; return '0; end
    lanes = vec ? (q ? 128 : 64) / w : 1;
    mask = (w == 64) ? {64'd0, {64{1'b1}}} : ((128'd1 << w) - 128'd1);
    for (int e = 0; e < lanes; e++) begin
      laneV = (op >> (e * w)) & mask;
      wide = laneV << sh;
      if ((wide >> w) != 0) begin sat = 1; wide = mask; end
      res = res | ((wide & mask) << (e * w));
    end
    return res;
  endfunction

  task automatic runOp(input string req, input logic [127:0] op, input logic [3:0] code,
      input logic [2:0] imm, input bit q, input bit vec, input bit clr);
    bit s, u, o;
    logic [127:0] exp;
    exp = model(op, code, imm, q, vec, s, u, o);
    @(negedge clk);
    operand = op; sizeCode = code; lowImm = imm; wideSel = q; vecMode = vec;
    inValid = 1'b1; clearSticky = clr;
    @(negedge clk);
    inValid = 1'b0; clearSticky = 1'b0;
    expSticky = (expSticky & ~clr) | (s & !u & !o);
    check({req, " result"}, result, exp);
    check({req, " outValid R9"}, 128'(outValid), 128'd1);
    check({req, " undefFlag"}, 128'(undefFlag), 128'(u));
    check({req, " otherClass"}, 128'(otherClass), 128'(o));
    check({req, " satSticky R8"}, 128'(satSticky), 128'(expSticky));
  endtask

  task automatic tReset();
    check("R10 outValid", 128'(outValid), 0);
    check("R10 result", result, 0);
    check("R10 flags", {undefFlag, otherClass, satSticky}, 0);
  endtask

  task automatic tBytes();   // R1 R2 R3: shift 3 on bytes, some overflow
    runOp("R1 R2 R3 bytes", 128'h1F20_0102_0304_0506_0708_090A_0B0C_FF00, 4'b0001, 3'd3, 1, 1, 0);
  endtask

  task automatic tNarrowHalf(); // R5: upper half would saturate but is ignored
    runOp("R5 half narrow", 128'hFFFF_FFFF_FFFF_FFFF_0001_01FF_0100_0003, 4'b0010, 3'd7, 0, 1, 1);
    runOp("R5 half narrow ovf", 128'hFFFF_FFFF_FFFF_FFFF_0001_0200_0100_0003, 4'b0010, 3'd7, 0, 1, 0);
  endtask

  task automatic tWordZero(); // R1 shift 0 boundary
    runOp("R1 word shift0", 128'hDEAD_BEEF_0123_4567_89AB_CDEF_FFFF_FFFF, 4'b0100, 3'd0, 1, 1, 1);
  endtask

  task automatic tDouble(); // R3 shift 63
    runOp("R3 dword shift63", {64'd2, 64'd1}, 4'b1111, 3'd7, 1, 1, 0);
  endtask

  task automatic tScalar(); // R4
    runOp("R4 scalar word", 128'hAAAA_5555_FFFF_0000_1234_5678_0000_07FF, 4'b0110, 3'd5, 0, 0, 1);
    runOp("R4 scalar word ovf", 128'hAAAA_5555_FFFF_0000_1234_5678_0000_0800, 4'b0110, 3'd5, 1, 0, 0);
    runOp("R4 scalar byte", 128'hFF01, 4'b0001, 3'd7, 0, 0, 1);
    runOp("R4 scalar byte ovf", 128'h0002, 4'b0001, 3'd7, 0, 0, 0);
    runOp("R4 scalar dword", {64'hFFFF, 64'h8000_0000_0000_0001}, 4'b1000, 3'd0, 0, 0, 1);
  endtask

  task automatic tIllegal(); // R6 R7
    runOp("R6 scalar zero code", 128'hFF, 4'b0000, 3'd5, 1, 0, 0);
    runOp("R6 vector zero code", 128'hFF, 4'b0000, 3'd5, 1, 1, 0);
    runOp("R7 reserved dword narrow", {128{1'b1}}, 4'b1000, 3'd4, 0, 1, 0);
  endtask

  task automatic tSticky(); // R8
    runOp("R8 set", 128'h80, 4'b0001, 3'd1, 0, 0, 0);
    runOp("R8 hold", 128'h01, 4'b0001, 3'd1, 0, 0, 0);
    runOp("R8 clear", 128'h01, 4'b0001, 3'd1, 0, 0, 1);
    runOp("R8 set wins", 128'h80, 4'b0001, 3'd1, 0, 0, 1);
  endtask

  task automatic tHold(); // R9: inputs ignored while inValid low
    logic [127:0] prev;
    prev = result;
    @(negedge clk);
    operand = {128{1'b1}}; sizeCode = 4'b0001; lowImm = 3'd7; vecMode = 1; wideSel = 1;
    @(negedge clk);
    check("R9 result held", result, prev);
    check("R9 outValid low", 128'(outValid), 0);
    check("R9 sticky held", 128'(satSticky), 128'(expSticky));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    tBytes();
    tNarrowHalf();
    tWordZero();
    tDouble();
    tScalar();
    tIllegal();
    tSticky();
    tHold();
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end
endmodule